// File: doc/BRIEF.md
# Trim DAC Code Selector with Voltage Profiles

This block chooses the 8-bit code that drives the trim DAC of each supply channel in a margining and trim subsystem. A 2-bit voltage profile selects which stored code every channel presents. One configuration bit decides whether that profile comes from two device pins or from two signals made by on-chip control logic. All channels see the same profile at all times. Profile 0 is the nominal setting. Profile 1 raises the supply by about 5 percent and profile 3 lowers it by about 5 percent. Profile 2 is a spare fixed setting.

Each channel holds four fixed codes, one for each profile, a code the host can write, and the code supplied by an external closed-loop trim engine. The fixed codes are captured from a configuration bus while reset is held. When the profile is 0, a per-channel mode field picks the fixed code, the host-written code or the closed-loop code. The output code is registered. A host write reaches the output in the same cycle that it updates the host register.

Top module: `trim_code_select`

## Requirements
- R1: While `rst_n` is low, every `dac_code_o` lane reads 0 after the next clock edge, every host code is cleared to 0, and each channel captures its four fixed codes from `fixed_codes_i`. The code for channel c and profile p sits at bits [c*32 + p*8 +: 8].
- R2: `use_int_prof_i`=0 takes the profile from `pin_prof_i`, and `use_int_prof_i`=1 takes it from `int_prof_i`. The source that is not selected has no effect.
- R3: Profile values 01, 10 and 11 select fixed code 1, 2 and 3 of each channel, whatever the channel's mode is.
- R4: Under profile 00, a channel whose mode field (`nom_mode_i` bits [c*2 +: 2]) is 00 or the spare value 11 outputs its fixed code 0.
- R5: Under profile 00, mode 01 outputs the channel's host register.
- R6: Under profile 00, mode 10 outputs the channel's lane of `loop_code_i` (bits [c*8 +: 8]) as it was at the previous clock edge.
- R7: Every output lane is a register. It shows the selection made from the inputs present at the preceding rising edge, so a change of profile, source or mode appears one clock later.
- R8: When `host_we_i` is high at an edge, `host_data_i` is stored in the host register of channel `host_ch_i` only. If that channel is selecting its host register at that edge, the written value is on its output after that same edge.
- R9: After reset is released, changes on `fixed_codes_i` have no effect on any output.
- R10: All channels use the same active profile in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the fixed codes |
| pin_prof_i | input | 2 | Profile from device pins |
| int_prof_i | input | 2 | Profile from internal control logic |
| use_int_prof_i | input | 1 | Profile source select: 1 = internal, 0 = pins |
| nom_mode_i | input | 2*CHANNELS | Per-channel profile-0 mode: 00 fixed, 01 host, 10 closed loop, 11 fixed |
| fixed_codes_i | input | 4*8*CHANNELS | Fixed codes captured during reset |
| host_we_i | input | 1 | Host write strobe |
| host_ch_i | input | CH_IDX_W (3) | Channel addressed by the host write |
| host_data_i | input | 8 | Host write data |
| loop_code_i | input | 8*CHANNELS | Codes from the closed-loop trim engine |
| dac_code_o | output | 8*CHANNELS | Registered DAC code per channel |

## Verification
The bench checks the host-write bypass on the exact edge of the write. A design without the bypass would show the previous host code for one extra cycle. Writes aimed at one channel are checked to leave every other channel unchanged. The bench also switches the profile source while the unselected source carries a different profile, which exposes an inverted select line. Mode 11 under profile 0 is checked to fall back to fixed code 0 rather than to the closed-loop code. The fixed-code bus is scrambled after reset, so a design that keeps reloading it would show the new values on the outputs.

// File: rtl/trim_sel_pkg.sv
package trim_sel_pkg;

    typedef enum logic [1:0] {
        PROF_NOM = 2'b00,
        PROF_HI  = 2'b01,
        PROF_AUX = 2'b10,
        PROF_LO  = 2'b11
    } prof_e;

    typedef enum logic [1:0] {
        NM_FIXED = 2'b00,
        NM_HOST  = 2'b01,
        NM_LOOP  = 2'b10,
        NM_SPARE = 2'b11
    } nom_mode_e;

    localparam int NUM_PROFILES = 4;

endpackage

// File: rtl/prof_src.sv
module prof_src
    import trim_sel_pkg::*;
(
    input  logic [1:0] pin_prof_i,
    input  logic [1:0] int_prof_i,
    input  logic       use_int_i,
    output prof_e      prof_o
);

    logic [1:0] raw;

    always_comb begin
        raw    = use_int_i ? int_prof_i : pin_prof_i;
        prof_o = prof_e'(raw);
    end

endmodule

// File: rtl/host_wr_dec.sv
module host_wr_dec #(
    parameter int CHANNELS = 8,
    localparam int IDX_W   = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [IDX_W-1:0]    idx_i,
    output logic [CHANNELS-1:0] en_o
);

    for (genvar g = 0; g < CHANNELS; g++) begin : g_en
        assign en_o[g] = we_i && (idx_i == IDX_W'(g));
    end

    // R8: a single write strobe never enables two channels
    assert_wr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_o));

    // R8: a write always reaches some channel
    assert_wr_reaches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (int'(idx_i) < CHANNELS)) |-> ($countones(en_o) == 1));

endmodule

// File: rtl/chan_code_sel.sv
module chan_code_sel
    import trim_sel_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  prof_e                               prof_i,
    input  nom_mode_e                           mode_i,
    input  logic [NUM_PROFILES-1:0][CODE_W-1:0] fixed_init_i,
    input  logic                                wr_en_i,
    input  logic [CODE_W-1:0]                   wr_data_i,
    input  logic [CODE_W-1:0]                   loop_code_i,
    output logic [CODE_W-1:0]                   code_o
);

    typedef struct packed {
        logic [NUM_PROFILES-1:0][CODE_W-1:0] fixed;
        logic [CODE_W-1:0]                   host;
        logic [CODE_W-1:0]                   code;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.host = wr_data_i;
        end
        unique case (prof_i)
            PROF_NOM: begin
                unique case (mode_i)
                    NM_HOST: st_d.code = st_d.host;
                    NM_LOOP: st_d.code = loop_code_i;
                    default: st_d.code = st_q.fixed[0];
                endcase
            end
            default: st_d.code = st_q.fixed[2'(prof_i)];
        endcase
        if (!rst_n) begin
            st_d.fixed = fixed_init_i;
            st_d.host  = '0;
            st_d.code  = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign code_o = st_q.code;

    // R3: margin and spare profiles take the matching fixed code
    assert_fixed_prof_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prof_i != PROF_NOM) |=> (code_o == $past(st_q.fixed[2'(prof_i)])));

    // R4: nominal profile in fixed or spare mode uses fixed code 0
    assert_nom_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prof_i == PROF_NOM && (mode_i == NM_FIXED || mode_i == NM_SPARE))
        |=> (code_o == $past(st_q.fixed[0])));

    // R5: nominal profile in host mode, no write, shows the host code
    assert_host_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prof_i == PROF_NOM && mode_i == NM_HOST && !wr_en_i)
        |=> (code_o == $past(st_q.host)));

    // R8: a write to a selected host register reaches the output at once
    assert_host_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prof_i == PROF_NOM && mode_i == NM_HOST && wr_en_i)
        |=> (code_o == $past(wr_data_i)));

    // R6: closed-loop mode forwards the engine code with one cycle of delay
    assert_loop_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prof_i == PROF_NOM && mode_i == NM_LOOP)
        |=> (code_o == $past(loop_code_i)));

    // R9: fixed codes never change once out of reset
    assert_fixed_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(st_q.fixed));

endmodule

// File: rtl/trim_code_select.sv
module trim_code_select
    import trim_sel_pkg::*;
#(
    parameter int CHANNELS = 8,
    parameter int CODE_W   = 8,
    localparam int CH_IDX_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1,
    localparam int FIX_W    = NUM_PROFILES * CODE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   pin_prof_i,
    input  logic [1:0]                   int_prof_i,
    input  logic                         use_int_prof_i,
    input  logic [2*CHANNELS-1:0]        nom_mode_i,
    input  logic [FIX_W*CHANNELS-1:0]    fixed_codes_i,
    input  logic                         host_we_i,
    input  logic [CH_IDX_W-1:0]          host_ch_i,
    input  logic [CODE_W-1:0]            host_data_i,
    input  logic [CODE_W*CHANNELS-1:0]   loop_code_i,
    output logic [CODE_W*CHANNELS-1:0]   dac_code_o
);

    prof_e               active_prof;
    logic [CHANNELS-1:0] wr_en;

    prof_src u_src (
        .pin_prof_i (pin_prof_i),
        .int_prof_i (int_prof_i),
        .use_int_i  (use_int_prof_i),
        .prof_o     (active_prof)
    );

    host_wr_dec #(.CHANNELS(CHANNELS)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (host_we_i),
        .idx_i (host_ch_i),
        .en_o  (wr_en)
    );

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        logic [NUM_PROFILES-1:0][CODE_W-1:0] fix_slice;
        nom_mode_e                           mode;

        assign fix_slice = fixed_codes_i[c*FIX_W +: FIX_W];
        assign mode      = nom_mode_e'(nom_mode_i[c*2 +: 2]);

        chan_code_sel #(.CODE_W(CODE_W)) u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .prof_i       (active_prof),
            .mode_i       (mode),
            .fixed_init_i (fix_slice),
            .wr_en_i      (wr_en[c]),
            .wr_data_i    (host_data_i),
            .loop_code_i  (loop_code_i[c*CODE_W +: CODE_W]),
            .code_o       (dac_code_o[c*CODE_W +: CODE_W])
        );
    end

endmodule

// File: tb/sim_trim_code_select.sv
`timescale 1ns/100ps
module sim_trim_code_select;

    localparam int CH = 8;
    localparam int W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       pin_prof = 2'd0;
    logic [1:0]       int_prof = 2'd0;
    logic             use_int = 1'b0;
    logic [2*CH-1:0]  nom_mode = '0;
    logic [32*CH-1:0] fixed_codes = '0;
    logic             host_we = 1'b0;
    logic [2:0]       host_ch = 3'd0;
    logic [W-1:0]     host_data = '0;
    logic [W*CH-1:0]  loop_code = '0;
    logic [W*CH-1:0]  dac_code;

    int tests = 0;
    int fails = 0;
    string phase = "R1";

    int fix_m [CH][4];
    int host_m [CH];
    int exp_m [CH];
    string tag_m [CH];

    always #2.5 clk = ~clk;

    trim_code_select u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .pin_prof_i     (pin_prof),
        .int_prof_i     (int_prof),
        .use_int_prof_i (use_int),
        .nom_mode_i     (nom_mode),
        .fixed_codes_i  (fixed_codes),
        .host_we_i      (host_we),
        .host_ch_i      (host_ch),
        .host_data_i    (host_data),
        .loop_code_i    (loop_code),
        .dac_code_o     (dac_code)
    );

    // Behavioural reference: inputs only change at negedge, so reading them here is race free
    always @(posedge clk) begin
        int prof;
        int md;
        prof = use_int ? int'(int_prof) : int'(pin_prof);
        for (int c = 0; c < CH; c++) begin
            if (!rst_n) begin
                for (int p = 0; p < 4; p++) fix_m[c][p] = int'(fixed_codes[c*32 + p*8 +: 8]);
                host_m[c] = 0;
                exp_m[c]  = 0;
                tag_m[c]  = "R1";
            end else begin
                if (host_we && int'(host_ch) == c) host_m[c] = int'(host_data);
                md = int'(nom_mode[c*2 +: 2]);
                if (prof != 0) begin
                    exp_m[c] = fix_m[c][prof]; tag_m[c] = "R3";
                end else if (md == 1) begin
                    exp_m[c] = host_m[c]; tag_m[c] = "R5";
                end else if (md == 2) begin
                    exp_m[c] = int'(loop_code[c*8 +: 8]); tag_m[c] = "R6";
                end else begin
                    exp_m[c] = fix_m[c][0]; tag_m[c] = "R4";
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
        for (int c = 0; c < CH; c++) begin
            int act;
            act = int'(dac_code[c*8 +: 8]);
            tests++;
            if (act !== exp_m[c]) begin
                fails++;
                $display("FAIL %s/%s ch%0d: dac_code=%0d expected %0d",
                         phase, tag_m[c], c, act, exp_m[c]);
            end
        end
    endtask

    task automatic set_fixed(input int salt);
        for (int c = 0; c < CH; c++)
            for (int p = 0; p < 4; p++)
                fixed_codes[c*32 + p*8 +: 8] = 8'((c*37 + p*61 + salt) & 8'hff);
    endtask

    task automatic set_modes(input int rot);
        for (int c = 0; c < CH; c++) nom_mode[c*2 +: 2] = 2'((c + rot) % 4);
    endtask

    task automatic set_loop(input int salt);
        for (int c = 0; c < CH; c++) loop_code[c*8 +: 8] = 8'((c*19 + salt*7 + 3) & 8'hff);
    endtask

    task automatic run_all();
        // R1: reset clears outputs and captures fixed codes
        set_fixed(11);
        set_modes(0);
        set_loop(1);
        pin_prof = 2'd2;
        repeat (3) step();
        rst_n = 1'b1;

        // R9: scramble the fixed bus after reset
        @(negedge clk);
        set_fixed(200);
        phase = "R9";

        // R3 R4 R7: walk pin profiles with all channels in fixed mode
        nom_mode = '0;
        for (int p = 0; p < 4; p++) begin
            phase = "R7";
            pin_prof = 2'(p);
            int_prof = 2'(3 - p);
            step();
            step();
        end

        // R2: internal source, pins hold a different profile
        phase = "R2";
        use_int = 1'b1;
        for (int p = 0; p < 4; p++) begin
            int_prof = 2'(p);
            pin_prof = 2'((p + 1) % 4);
            step();
        end
        use_int = 1'b0;
        pin_prof = 2'd0;
        int_prof = 2'd3;
        step();

        // R4 R5 R6: mixed modes under profile 0, loop codes moving
        phase = "R6";
        for (int r = 0; r < 4; r++) begin
            set_modes(r);
            for (int k = 0; k < 3; k++) begin
                set_loop(r*5 + k);
                step();
            end
        end

        // R8: host writes, bypass on selected channels, isolation on others
        phase = "R8";
        set_modes(1);
        for (int c = 0; c < CH; c++) begin
            host_we   = 1'b1;
            host_ch   = 3'(c);
            host_data = 8'(8'hA0 + c*3);
            step();
        end
        host_we = 1'b0;
        step();
        // R5: host codes written while a margin profile is active appear on return to 0
        phase = "R5";
        nom_mode = {CH{2'b01}};
        pin_prof = 2'd1;
        for (int c = 0; c < CH; c++) begin
            host_we = 1'b1;
            host_ch = 3'(c);
            host_data = 8'(8'h10 + c*29);
            step();
        end
        host_we = 1'b0;
        pin_prof = 2'd0;
        step();
        step();
        // back-to-back writes to one selected channel
        phase = "R8";
        for (int k = 0; k < 4; k++) begin
            host_we = 1'b1;
            host_ch = 3'd5;
            host_data = 8'(k*64 + 7);
            step();
        end
        host_we = 1'b0;

        // R10 R7: profile and source change every cycle
        phase = "R10";
        set_modes(2);
        for (int k = 0; k < 16; k++) begin
            use_int  = k[0];
            pin_prof = 2'(k / 2);
            int_prof = 2'(k + 1);
            set_loop(k);
            step();
        end

        // R1: reset reasserted mid-run clears outputs and reloads fixed codes
        phase = "R1";
        rst_n = 1'b0;
        set_fixed(77);
        step();
        step();
        rst_n = 1'b1;
        phase = "R3";
        for (int p = 0; p < 4; p++) begin
            pin_prof = 2'(p);
            step();
        end
    endtask

    initial begin
        bit done;
        done = 1'b0;
        fork
            begin
                run_all();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
            end
        join_any
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run_all finished=%0d expected 1", done);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule